// File: doc/BRIEF.md
# Descriptor-Driven Configuration DMA Engine

This block is the bulk-transfer companion to a selector-indexed configuration item port. Host software loads a 64-bit pointer to a 16-byte descriptor in memory, split into two 32-bit halves, and writing the low half launches the transfer. The engine reads the descriptor through a byte-wide memory master port. The descriptor may select a new item. It then moves bytes from the item into a memory buffer, moves bytes from a buffer into a writable item, or only advances the item offset. When the transfer finishes, the engine writes a status word back over the descriptor's control word.

The item contents live outside the block. The engine drives an item key and a byte offset. The item store answers combinationally with the item's size, whether it is writable, and the byte at that offset. The engine writes item bytes with a one-cycle strobe. The memory port uses valid/ready on both the request and the response channel. A request stays stable until `mem_req_ready` is seen high at a clock edge. Only one read is in flight at a time, and `mem_rsp_ready` is high only while the engine waits for that read's byte. Write requests get no response.

Descriptor layout. All fields are big-endian. Bytes 0..3 hold the control word, bytes 4..7 the length, and bytes 8..15 the buffer address. The control word bits are:
- bit 0: error
- bit 1: read
- bit 2: skip
- bit 3: select, with the key in bits 31..16
- bit 4: write

Top module: `cfg_dma_engine`

## Requirements
- R1: After reset `busy` is 0, no memory request or item write is issued, and `host_rdata` always returns the fixed 64-bit signature parameter.
- R2: A pulse on `host_wr_lo` while idle starts a transfer at descriptor address {high half, low half}. The high half comes from `host_wdata_hi` when `host_wr_hi` is pulsed in the same cycle (a 64-bit write), and otherwise from an earlier `host_wr_hi` pulse.
- R3: The stored high half returns to 0 when each transfer completes, so a later low-only trigger fetches from an address whose upper 32 bits are 0.
- R4: Address-register writes made while `busy` is 1 are ignored and start no further transfer.
- R5: The descriptor is fetched as 16 byte reads in ascending address order, with the field layout given above.
- R6: When control bit 3 is set, the item key becomes control bits 31..16 and the item offset becomes 0, before any data operation.
- R7: When control bit 1 is set, `length` bytes starting at the current offset are written to the buffer in ascending order, and the offset then advances by `length`. This takes priority over bits 4 and 2.
- R8: A read byte whose offset is at or past the item size is written as 0x00, and this does not set the error flag.
- R9: When control bit 4 is set and bit 1 is clear, `length` bytes read from the buffer are written into the item at ascending offsets, and the offset advances by `length`.
- R10: A write whose offset plus length exceeds the item size, or whose item is not writable, changes no item byte, leaves the offset unchanged, and reports an error.
- R11: When control bit 2 is set and bits 1 and 4 are clear, the offset advances by `length` and no buffer or item byte moves.
- R12: On completion the engine writes 4 big-endian bytes at the descriptor address: 0x00000000 on success and 0x00000001 on error. `busy` then falls.
- R13: A memory request held with valid high and ready low keeps its address, direction and data. No new request is issued while a read response is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_hi | input | 1 | Write strobe for the high address half |
| host_wr_lo | input | 1 | Write strobe for the low address half; starts a transfer |
| host_wdata_hi | input | 32 | High address half |
| host_wdata_lo | input | 32 | Low address half |
| host_rdata | output | 64 | Read value of the address register (signature) |
| busy | output | 1 | Transfer in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = byte write, 0 = byte read |
| mem_req_addr | output | 64 | Byte address |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_ready | output | 1 | Engine is waiting for a read byte |
| mem_rsp_data | input | 8 | Read byte |
| item_key | output | 16 | Currently selected item key |
| item_off | output | 32 | Item byte offset being accessed |
| item_size | input | 32 | Size in bytes of the selected item |
| item_writable | input | 1 | Selected item accepts writes |
| item_rd_data | input | 8 | Item byte at `item_off` |
| item_wr_en | output | 1 | Item byte write strobe |
| item_wr_data | output | 8 | Item byte to write |

## Verification
The bound checker watches the memory port handshake on every cycle. It checks that a stalled request stays stable, that nothing is issued while a read is outstanding, and that the engine is silent when idle. It also checks that every item write follows an accepted response byte and targets a writable item. The bench scenarios are the only place to show the data results: the bytes copied to and from the buffer, the zero fill past an item's end, the offset carried between transfers, the rejected out-of-range and read-only writes, the status word, and the high address half clearing between transfers.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FREQ,
    ST_FRSP,
    ST_SEL,
    ST_EXEC,
    ST_RDREQ,
    ST_WRREQ,
    ST_WRRSP,
    ST_WBREQ,
    ST_DONE
  } dma_state_t;

  localparam int unsigned CB_ERR   = 0;
  localparam int unsigned CB_READ  = 1;
  localparam int unsigned CB_SKIP  = 2;
  localparam int unsigned CB_SEL   = 3;
  localparam int unsigned CB_WRITE = 4;
  localparam int unsigned CTRL_W   = 32;
  localparam int unsigned DESC_BYTES = 16;
endpackage

// File: rtl/cfgdma_trigger.sv
module cfgdma_trigger #(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [ADDR_W/2-1:0] data_hi,
  input  logic [ADDR_W/2-1:0] data_lo,
  input  logic              block,
  input  logic              clear,
  output logic              start,
  output logic [ADDR_W-1:0] start_addr
);
  localparam int unsigned HALF = ADDR_W / 2;

  logic [HALF-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q       <= '0;
      start      <= 1'b0;
      start_addr <= '0;
    end else begin
      start <= 1'b0;
      if (clear) begin
        hi_q <= '0;
      end else if (!block && !start) begin
        if (wr_hi) hi_q <= data_hi;
        if (wr_lo) begin
          start      <= 1'b1;
          start_addr <= {(wr_hi ? data_hi : hi_q), data_lo};
        end
      end
    end
  end
endmodule

// File: rtl/cfgdma_desc.sv
module cfgdma_desc #(
  parameter int unsigned NBYTES = 16,
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic [7:0]        byte_in,
  output logic [31:0]       ctrl,
  output logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] buf_addr
);
  localparam int unsigned W = NBYTES * 8;

  logic [7:0] bytes_q [NBYTES];
  logic [W-1:0] flat;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int i = 0; i < NBYTES; i++) bytes_q[i] <= '0;
    end else if (shift_en) begin
      for (int i = 0; i < NBYTES - 1; i++) bytes_q[i] <= bytes_q[i+1];
      bytes_q[NBYTES-1] <= byte_in;
    end
  end

  // first fetched byte ends in slot 0 and is most significant
  for (genvar g = 0; g < NBYTES; g++) begin : g_flat
    assign flat[W-1-8*g -: 8] = bytes_q[g];
  end

  assign ctrl     = flat[W-1 -: 32];
  assign len      = flat[W-33 -: LEN_W];
  assign buf_addr = flat[W-33-LEN_W -: ADDR_W];
endmodule

// File: rtl/cfgdma_bounds.sv
module cfgdma_bounds #(
  parameter int unsigned LEN_W = 32
) (
  input  logic [LEN_W-1:0] cur_off,
  input  logic [LEN_W-1:0] cnt,
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] size,
  input  logic             writable,
  output logic             past_end,
  output logic             write_ok
);
  logic [LEN_W:0] rd_pos;
  logic [LEN_W:0] wr_end;

  always_comb begin
    rd_pos   = {1'b0, cur_off} + {1'b0, cnt};
    wr_end   = {1'b0, cur_off} + {1'b0, len};
    past_end = rd_pos >= {1'b0, size};
    write_ok = writable && (wr_end <= {1'b0, size});
  end
endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
  import cfgdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned LEN_W  = 32,
  parameter int unsigned KEY_W  = 16,
  parameter logic [63:0] SIGNATURE = 64'h4346_4744_4D41_3031
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr_hi,
  input  logic                host_wr_lo,
  input  logic [ADDR_W/2-1:0] host_wdata_hi,
  input  logic [ADDR_W/2-1:0] host_wdata_lo,
  output logic [63:0]         host_rdata,
  output logic                busy,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_write,
  output logic [ADDR_W-1:0]   mem_req_addr,
  output logic [7:0]          mem_req_wdata,
  input  logic                mem_rsp_valid,
  output logic                mem_rsp_ready,
  input  logic [7:0]          mem_rsp_data,
  output logic [KEY_W-1:0]    item_key,
  output logic [LEN_W-1:0]    item_off,
  input  logic [LEN_W-1:0]    item_size,
  input  logic                item_writable,
  input  logic [7:0]          item_rd_data,
  output logic                item_wr_en,
  output logic [7:0]          item_wr_data
);
  localparam int unsigned IDX_W      = $clog2(DESC_BYTES);
  localparam int unsigned STAT_BYTES = CTRL_W / 8;

  dma_state_t        state;
  logic              start;
  logic [ADDR_W-1:0] start_addr;
  logic [ADDR_W-1:0] desc_base;
  logic [IDX_W-1:0]  idx;
  logic [LEN_W-1:0]  cnt;
  logic [LEN_W-1:0]  cur_off;
  logic [KEY_W-1:0]  cur_key;
  logic              err;
  logic              done;
  logic              desc_shift;
  logic              desc_clr;
  logic [31:0]       d_ctrl;
  logic [LEN_W-1:0]  d_len;
  logic [ADDR_W-1:0] d_buf;
  logic              past_end;
  logic              write_ok;
  logic              req_fire;
  logic              rsp_fire;
  logic              last_byte;
  logic [7:0]        stat_byte [STAT_BYTES];

  assign host_rdata = SIGNATURE;
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_DONE);
  assign req_fire   = mem_req_valid && mem_req_ready;
  assign rsp_fire   = mem_rsp_valid && mem_rsp_ready;
  assign last_byte  = (cnt + 1'b1) == d_len;
  assign desc_clr   = start;
  assign desc_shift = (state == ST_FRSP) && mem_rsp_valid;
  assign item_key   = cur_key;
  assign item_off   = cur_off + cnt;

  // status word, big-endian: error flag lands in the final byte
  for (genvar g = 0; g < STAT_BYTES; g++) begin : g_stat
    if (g == STAT_BYTES - 1) begin : g_low
      assign stat_byte[g] = {7'b0, err};
    end else begin : g_hi
      assign stat_byte[g] = 8'h00;
    end
  end

  cfgdma_trigger #(.ADDR_W(ADDR_W)) u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_hi      (host_wr_hi),
    .wr_lo      (host_wr_lo),
    .data_hi    (host_wdata_hi),
    .data_lo    (host_wdata_lo),
    .block      (busy),
    .clear      (done),
    .start      (start),
    .start_addr (start_addr)
  );

  cfgdma_desc #(.NBYTES(DESC_BYTES), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_desc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (desc_clr),
    .shift_en (desc_shift),
    .byte_in  (mem_rsp_data),
    .ctrl     (d_ctrl),
    .len      (d_len),
    .buf_addr (d_buf)
  );

  cfgdma_bounds #(.LEN_W(LEN_W)) u_bounds (
    .cur_off  (cur_off),
    .cnt      (cnt),
    .len      (d_len),
    .size     (item_size),
    .writable (item_writable),
    .past_end (past_end),
    .write_ok (write_ok)
  );

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = '0;
    mem_req_wdata = 8'h00;
    mem_rsp_ready = 1'b0;
    item_wr_en    = 1'b0;
    item_wr_data  = mem_rsp_data;
    unique case (state)
      ST_FREQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = desc_base + ADDR_W'(idx);
      end
      ST_FRSP: mem_rsp_ready = 1'b1;
      ST_RDREQ: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = d_buf + ADDR_W'(cnt);
        mem_req_wdata = past_end ? 8'h00 : item_rd_data;
      end
      ST_WRREQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = d_buf + ADDR_W'(cnt);
      end
      ST_WRRSP: begin
        mem_rsp_ready = 1'b1;
        item_wr_en    = mem_rsp_valid;
      end
      ST_WBREQ: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = desc_base + ADDR_W'(idx);
        mem_req_wdata = stat_byte[idx[$clog2(STAT_BYTES)-1:0]];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      desc_base <= '0;
      idx       <= '0;
      cnt       <= '0;
      cur_off   <= '0;
      cur_key   <= '0;
      err       <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          desc_base <= start_addr;
          idx       <= '0;
          err       <= 1'b0;
          state     <= ST_FREQ;
        end
        ST_FREQ: if (req_fire) state <= ST_FRSP;
        ST_FRSP: if (rsp_fire) begin
          if (idx == IDX_W'(DESC_BYTES - 1)) begin
            state <= ST_SEL;
          end else begin
            idx   <= idx + 1'b1;
            state <= ST_FREQ;
          end
        end
        ST_SEL: begin
          if (d_ctrl[CB_SEL]) begin
            cur_key <= d_ctrl[31 -: KEY_W];
            cur_off <= '0;
          end
          cnt   <= '0;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          idx   <= '0;
          state <= ST_WBREQ;
          if (d_ctrl[CB_READ]) begin
            if (d_len != '0) state <= ST_RDREQ;
          end else if (d_ctrl[CB_WRITE]) begin
            if (!write_ok) err <= 1'b1;
            else if (d_len != '0) state <= ST_WRREQ;
          end else if (d_ctrl[CB_SKIP]) begin
            cur_off <= cur_off + d_len;
          end
        end
        ST_RDREQ: if (req_fire) begin
          if (last_byte) begin
            cur_off <= cur_off + d_len;
            cnt     <= '0;
            state   <= ST_WBREQ;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WRREQ: if (req_fire) state <= ST_WRRSP;
        ST_WRRSP: if (rsp_fire) begin
          if (last_byte) begin
            cur_off <= cur_off + d_len;
            cnt     <= '0;
            state   <= ST_WBREQ;
          end else begin
            cnt   <= cnt + 1'b1;
            state <= ST_WRREQ;
          end
        end
        ST_WBREQ: if (req_fire) begin
          if (idx == IDX_W'(STAT_BYTES - 1)) state <= ST_DONE;
          else idx <= idx + 1'b1;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_dma_checker.sv
module cfg_dma_checker #(
  parameter int unsigned ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [7:0]        mem_req_wdata,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_ready,
  input logic              item_wr_en,
  input logic              item_writable
);
  logic rd_out;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_out <= 1'b0;
    else if (mem_req_valid && mem_req_ready && !mem_req_write) rd_out <= 1'b1;
    else if (mem_rsp_valid && mem_rsp_ready) rd_out <= 1'b0;
  end

  // R13: a stalled request holds its contents
  a_r13_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  // R13: one read in flight at most
  a_r13_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out |-> !mem_req_valid);

  // R1: idle engine is silent on both sides
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req_valid && !mem_rsp_ready && !item_wr_en));

  // R10: item bytes only change on writable items
  a_r10_no_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
    item_wr_en |-> item_writable);

  // R9: every item byte written comes from an accepted response
  a_r9_wr_from_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    item_wr_en |-> (mem_rsp_valid && mem_rsp_ready && rd_out));
endmodule

bind cfg_dma_engine cfg_dma_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_ready (mem_rsp_ready),
  .item_wr_en    (item_wr_en),
  .item_writable (item_writable)
);

// File: tb/tb_cfg_dma_engine.sv
`timescale 1ns/1ps
module tb_cfg_dma_engine;
  localparam logic [63:0] SIG = 64'h4346_4744_4D41_3031;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        host_wr_hi = 0, host_wr_lo = 0;
  logic [31:0] host_wdata_hi = 0, host_wdata_lo = 0;
  logic [63:0] host_rdata;
  logic        busy;
  logic        mem_req_valid, mem_req_write, mem_rsp_ready;
  logic        mem_req_ready = 0, mem_rsp_valid = 0;
  logic [63:0] mem_req_addr;
  logic [7:0]  mem_req_wdata, mem_rsp_data = 0;
  logic [15:0] item_key;
  logic [31:0] item_off, item_size;
  logic        item_writable, item_wr_en;
  logic [7:0]  item_rd_data, item_wr_data;

  logic [7:0] mem [4096];
  logic [7:0] item_mem [4][32];
  logic [7:0] exp_item [4][32];
  logic [7:0] exp_buf [32];
  int unsigned sizes [4] = '{8, 20, 5, 12};

  int n_chk = 0, n_bad = 0;
  logic        pend = 0;
  logic [11:0] pend_addr = 0;
  logic        cap_arm = 0;
  logic [63:0] cap_addr = 0;
  logic [15:0] m_key = 0;
  logic [31:0] m_off = 0;

  cfg_dma_engine dut (.*);

  assign item_size     = (item_key < 4) ? sizes[item_key[1:0]] : 32'd0;
  assign item_writable = (item_key == 16'd1) || (item_key == 16'd3);
  assign item_rd_data  = (item_key < 4 && item_off < 32) ? item_mem[item_key[1:0]][item_off[4:0]] : 8'h00;

  // memory responder
  always @(negedge clk) begin
    mem_req_ready = ($urandom % 4) != 0;
    if (!pend) mem_rsp_valid = 1'b0;
    else if (!mem_rsp_valid && ($urandom % 2) == 0) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem[pend_addr];
    end
  end

  always @(posedge clk) begin
    if (mem_rsp_valid && mem_rsp_ready) pend = 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) mem[mem_req_addr[11:0]] = mem_req_wdata;
      else begin
        pend = 1'b1;
        pend_addr = mem_req_addr[11:0];
        if (cap_arm) begin cap_addr = mem_req_addr; cap_arm = 0; end
      end
    end
    if (item_wr_en && item_key < 4 && item_off < 32)
      item_mem[item_key[1:0]][item_off[4:0]] = item_wr_data;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // run one descriptor; mode 0: 64-bit write, 1: hi then lo, 2: lo only
  task automatic do_op(input logic [31:0] ctrl, input logic [31:0] len, input logic [11:0] daddr,
                       input logic [11:0] baddr, input logic [31:0] hi, input int mode,
                       input bit poke, input string tag);
    bit err = 0, ok;
    int t;
    int bad_buf = 0, bad_item = 0;
    logic [63:0] exp_fetch;
    logic [31:0] st;
    logic [127:0] d;
    @(negedge clk);
    if (ctrl[3]) begin m_key = ctrl[31:16]; m_off = 0; end
    if (ctrl[1]) begin
      for (int i = 0; i < len; i++) begin
        mem[baddr + 12'(i)] = 8'h5A;
        exp_buf[i] = (m_key < 4 && ({1'b0, m_off} + 33'(i)) < 33'(sizes[m_key[1:0]]))
                     ? exp_item[m_key[1:0]][m_off + 32'(i)] : 8'h00;
      end
      m_off = m_off + len;
    end else if (ctrl[4]) begin
      ok = (m_key == 1 || m_key == 3) && (({1'b0, m_off} + {1'b0, len}) <= 33'(sizes[m_key[1:0]]));
      for (int i = 0; i < len; i++) begin
        mem[baddr + 12'(i)] = 8'($urandom);
        if (ok) exp_item[m_key[1:0]][m_off + 32'(i)] = mem[baddr + 12'(i)];
      end
      if (ok) m_off = m_off + len; else err = 1;
    end else if (ctrl[2]) m_off = m_off + len;
    d = {ctrl, len, 52'h0, baddr};
    for (int i = 0; i < 16; i++) mem[daddr + 12'(i)] = d[127 - 8*i -: 8];
    exp_fetch = (mode == 2) ? {32'h0, 20'h0, daddr} : {hi, 20'h0, daddr};
    cap_arm = 1;
    if (mode == 1) begin
      host_wr_hi = 1; host_wdata_hi = hi;
      @(negedge clk); host_wr_hi = 0;
    end
    host_wr_hi = (mode == 0); host_wdata_hi = hi;
    host_wr_lo = 1; host_wdata_lo = {20'h0, daddr};
    @(negedge clk); host_wr_hi = 0; host_wr_lo = 0;
    t = 0;
    while (!busy && t < 50) begin @(negedge clk); t++; end
    if (poke) begin
      host_wr_hi = 1; host_wdata_hi = 32'hFFFF_0000;
      host_wr_lo = 1; host_wdata_lo = 32'h0000_0F00;
      @(negedge clk); host_wr_hi = 0; host_wr_lo = 0;
    end
    t = 0;
    while (busy && t < 2000) begin @(negedge clk); t++; end
    chk(!busy, {tag, " R12 completes"}, 64'(busy), 64'd0);
    chk(cap_addr == exp_fetch, {tag, " R2 R3 R5 descriptor address"}, cap_addr, exp_fetch);
    st = {mem[daddr], mem[daddr + 1], mem[daddr + 2], mem[daddr + 3]};
    chk(st == {31'b0, err}, {tag, " R12 R10 status word"}, 64'(st), 64'(err));
    if (ctrl[1]) begin
      for (int i = 0; i < len; i++) if (mem[baddr + 12'(i)] != exp_buf[i]) bad_buf++;
      chk(bad_buf == 0, {tag, " R7 R8 buffer bytes"}, 64'(bad_buf), 64'd0);
    end
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 32; j++) if (item_mem[k][j] != exp_item[k][j]) bad_item++;
    chk(bad_item == 0, {tag, " R9 R10 R11 item bytes"}, 64'(bad_item), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 32; j++) begin
        item_mem[k][j] = 8'($urandom);
        exp_item[k][j] = item_mem[k][j];
      end
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req_valid && !item_wr_en, "R1 reset idle", {busy, mem_req_valid, item_wr_en}, 64'd0);
    chk(host_rdata == SIG, "R1 signature", host_rdata, SIG);
    rst_n = 1;
    @(negedge clk);
    // directed
    do_op(32'h0001_000A, 20, 12'h010, 12'h200, 0, 0, 0, "R6 R7 full read");
    do_op(32'h0002_000A, 8, 12'h020, 12'h240, 0, 2, 0, "R8 read past end");
    do_op(32'h0001_0018, 4, 12'h030, 12'h280, 0, 0, 0, "R9 write in range");
    do_op(32'h0000_0004, 14, 12'h040, 12'h2C0, 0, 2, 0, "R11 skip");
    do_op(32'h0000_0010, 4, 12'h050, 12'h300, 0, 2, 0, "R10 write overflow");
    do_op(32'h0000_0002, 2, 12'h060, 12'h340, 0, 2, 0, "R10 offset kept");
    do_op(32'h0000_0018, 2, 12'h070, 12'h380, 32'h0000_1234, 1, 0, "R10 readonly R2 split");
    do_op(32'h0003_0012, 3, 12'h080, 12'h3C0, 0, 2, 0, "R7 priority R3 lo only");
    do_op(32'h0003_0018, 0, 12'h090, 12'h400, 32'hABCD_0001, 0, 0, "R9 zero length");
    do_op(32'h0003_0018, 12, 12'h0A0, 12'h440, 0, 2, 0, "R10 end exactly fits");
    do_op(32'h0001_0002, 6, 12'h0B0, 12'h480, 0, 2, 1, "R4 busy poke");
    repeat (6) @(negedge clk);
    chk(!busy && !mem_req_valid, "R4 write while busy ignored", 64'(busy), 64'd0);
    // random
    for (int n = 0; n < 60; n++) begin
      logic [31:0] c;
      logic [15:0] key;
      int op;
      key = (($urandom % 8) == 0) ? 16'd7 : 16'($urandom % 4);
      op = $urandom % 4;
      c = {key, 11'h0, (op == 2) ? 5'h10 : (op == 0) ? 5'h02 : (op == 1) ? 5'h04 : 5'h00};
      if (($urandom % 2) == 0) c[3] = 1'b1;
      do_op(c, $urandom % 13, 12'(16 * (n % 16)) + 12'h100, 12'h600 + 12'(32 * (n % 16)),
            $urandom, $urandom % 3, 0, "random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule